// File: doc/BRIEF.md
# System Clock Source Switcher

This block decides which of two high-speed oscillators, an RC source or a crystal source, drives the system clock. Software requests a source with a select bit. The block turns on the oscillator it needs and waits until that oscillator reports stable. Only then does it move the clock over. It reports the source that is really in use on its own output. That output can lag the request for as long as the target oscillator needs to settle.

A single power-down input turns off the high-speed oscillator that is not in use. The one exception is an oscillator the block is currently switching toward. While the chip sleeps in a low-power mode, both high-speed oscillators are off. On wake the clock always restarts on the RC source. If the crystal was the active source before sleep, the block powers the crystal up again and moves back to it on its own once the crystal is stable.

An optional settle wait of a fixed number of microseconds can follow the crystal-stable flag. It is counted in system clock cycles. A clock-divider field is carried as a plain registered value.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is held and on the first cycle after it, the active source is RC (src_xo_o = 0), busy_o = 0, rc_en_o = 1, clk_div_o = 0, and xo_en_o equals the inverse of osc_pd_i.
- R2: src_xo_o (1 = crystal, 0 = RC) changes only after the target oscillator's stable input has been sampled high, apart from the forced return to RC on wake. While the target is not stable, busy_o stays 1 and src_xo_o keeps its old value.
- R3: When awake, the enable of the active source is 1. The enable of the other source is 1 when osc_pd_i = 0 and 0 when osc_pd_i = 1, unless a switch toward that source is pending.
- R4: While a switch is pending, the target oscillator's enable is 1 whatever the value of osc_pd_i.
- R5: With the settle wait enabled, a switch to the crystal completes CLK_MHZ*SETTLE_US cycles after crystal-stable is first sampled high. If crystal-stable drops during that wait, the wait restarts from zero.
- R6: A switch to the RC source has no settle wait. It completes on the edge after RC-stable is seen, two edges after the request when RC is already stable.
- R7: A change of sel_xo_i while a switch is pending does not alter the pending target. The pending switch completes first, and any new request is served afterwards.
- R8: While sleep_i is high (low-power modes 1 to 3), rc_en_o and xo_en_o are both 0.
- R9: On the first cycle after sleep_i falls, the active source is RC. If the crystal was the active source before sleep, xo_en_o is 1, a switch to the crystal is pending, and it completes once the crystal is stable (plus the settle wait).
- R10: deep_ok_o, the permit for modes 2 and 3, is 1 only while RC is the active source and no switch is pending.
- R11: clk_div_o equals clk_div_i as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_xo_i | input | 1 | Requested source, 1 = crystal, 0 = RC |
| osc_pd_i | input | 1 | Power down the unused high-speed oscillator |
| rc_stable_i | input | 1 | RC oscillator reports stable |
| xo_stable_i | input | 1 | Crystal oscillator reports stable |
| sleep_i | input | 1 | High while the chip is in low-power mode 1 to 3 |
| clk_div_i | input | DIV_W | Clock divider field written by software |
| rc_en_o | output | 1 | RC oscillator enable |
| xo_en_o | output | 1 | Crystal oscillator enable |
| src_xo_o | output | 1 | Source actually driving the clock, 1 = crystal |
| busy_o | output | 1 | A source switch is pending |
| deep_ok_o | output | 1 | RC is active and idle, so modes 2 and 3 may be entered |
| clk_div_o | output | DIV_W | Registered clock divider field |

## Verification
The assertions check these properties on every cycle:
- a rise or fall of the active source is always preceded by the matching stable flag or by a wake;
- the pending target stays fixed while busy;
- both enables are low in sleep;
- the active and pending oscillators are powered;
- the deep-sleep permit never shows while the crystal is active.

Some behaviour only the bench's scenarios can show:
- the exact length of the settle wait and its restart when crystal-stable drops;
- the ordering of a request withdrawn mid-switch;
- the automatic return to the crystal after wake, compared with a wake that had only RC running.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic {
        SRC_RC = 1'b0,
        SRC_XO = 1'b1
    } src_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETTLE,
        ST_SLEEP
    } sw_state_t;

    // Status carried from the sequencer to the enable logic
    typedef struct packed {
        logic asleep;
        logic busy;
        src_t tgt;
        src_t act;
    } sw_stat_t;

    function automatic int unsigned settle_cycles(input int unsigned mhz,
                                                  input int unsigned us);
        return mhz * us;
    endfunction

    function automatic logic src_stable(input src_t s, input logic rc_stb,
                                        input logic xo_stb);
        return (s == SRC_XO) ? xo_stb : rc_stb;
    endfunction

endpackage

// File: rtl/clksw_settle.sv
module clksw_settle #(
    parameter int unsigned LIM = 3200,
    parameter bit          USE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = (LIM > 1) ? $clog2(LIM) : 1;

    generate
        if (USE) begin : g_cnt
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || !run_i) cnt_q <= '0;
                else               cnt_q <= cnt_q + 1'b1;
            end
            assign done_o = run_i && (cnt_q == CW'(LIM - 1));

            // R5: the count never passes the limit while running
            cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
                run_i |-> (cnt_q <= CW'(LIM - 1)));
        end else begin : g_none
            assign done_o = run_i;
        end
    endgenerate

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter bit USE_SETTLE = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_xo_i,
    input  logic     sleep_i,
    input  logic     rc_stable_i,
    input  logic     xo_stable_i,
    input  logic     settle_done_i,
    output logic     settle_run_o,
    output sw_stat_t stat_o
);
    sw_state_t state_q;
    src_t      act_q, tgt_q;
    logic      was_xo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            act_q    <= SRC_RC;
            tgt_q    <= SRC_RC;
            was_xo_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (sleep_i) begin
                        state_q  <= ST_SLEEP;
                        was_xo_q <= (act_q == SRC_XO);
                    end else if (src_t'(sel_xo_i) != act_q) begin
                        tgt_q   <= src_t'(sel_xo_i);
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (sleep_i) begin
                        state_q  <= ST_SLEEP;
                        was_xo_q <= (act_q == SRC_XO);
                    end else if (src_stable(tgt_q, rc_stable_i, xo_stable_i)) begin
                        if (tgt_q == SRC_XO && USE_SETTLE) begin
                            state_q <= ST_SETTLE;
                        end else begin
                            act_q   <= tgt_q;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (sleep_i) begin
                        state_q  <= ST_SLEEP;
                        was_xo_q <= (act_q == SRC_XO);
                    end else if (!xo_stable_i) begin
                        state_q <= ST_WAIT;
                    end else if (settle_done_i) begin
                        act_q   <= SRC_XO;
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    if (!sleep_i) begin
                        act_q <= SRC_RC;
                        if (was_xo_q) begin
                            tgt_q   <= SRC_XO;
                            state_q <= ST_WAIT;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    assign settle_run_o  = (state_q == ST_SETTLE);
    assign stat_o.asleep = (state_q == ST_SLEEP);
    assign stat_o.busy   = (state_q == ST_WAIT) || (state_q == ST_SETTLE);
    assign stat_o.tgt    = tgt_q;
    assign stat_o.act    = act_q;

    // R2
    xo_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q == SRC_XO && $past(act_q) == SRC_RC) |-> $past(xo_stable_i));
    // R2
    rc_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q == SRC_RC && $past(act_q) == SRC_XO)
            |-> ($past(rc_stable_i) || $past(state_q) == ST_SLEEP));
    // R9
    wake_rc_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_SLEEP && state_q != ST_SLEEP) |-> (act_q == SRC_RC));
    // R7
    tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_o.busy && $past(stat_o.busy)) |-> $stable(tgt_q));

endmodule

// File: rtl/clksw_osc_ctl.sv
module clksw_osc_ctl
    import clksw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sw_stat_t stat_i,
    input  logic     pd_i,
    output logic     rc_en_o,
    output logic     xo_en_o
);
    logic rc_need, xo_need;

    always_comb begin
        rc_need = (stat_i.act == SRC_RC) || (stat_i.busy && stat_i.tgt == SRC_RC);
        xo_need = (stat_i.act == SRC_XO) || (stat_i.busy && stat_i.tgt == SRC_XO);
        rc_en_o = !stat_i.asleep && (rc_need || !pd_i);
        xo_en_o = !stat_i.asleep && (xo_need || !pd_i);
    end

    // R8
    sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
        stat_i.asleep |-> (!rc_en_o && !xo_en_o));
    // R3
    active_on_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_i.asleep |-> ((stat_i.act == SRC_XO) ? xo_en_o : rc_en_o));
    // R4
    pend_on_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_i.busy && stat_i.tgt == SRC_XO) |-> xo_en_o);

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clksw_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 50,
    parameter int unsigned SETTLE_US = 64,
    parameter bit          SETTLE_EN = 1'b1,
    parameter int unsigned DIV_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_xo_i,
    input  logic             osc_pd_i,
    input  logic             rc_stable_i,
    input  logic             xo_stable_i,
    input  logic             sleep_i,
    input  logic [DIV_W-1:0] clk_div_i,
    output logic             rc_en_o,
    output logic             xo_en_o,
    output logic             src_xo_o,
    output logic             busy_o,
    output logic             deep_ok_o,
    output logic [DIV_W-1:0] clk_div_o
);
    localparam int unsigned SETTLE_LIM = settle_cycles(CLK_MHZ, SETTLE_US);
    localparam bit          USE_SETTLE = SETTLE_EN && (SETTLE_LIM > 0);

    sw_stat_t         stat;
    logic             settle_run, settle_done;
    logic [DIV_W-1:0] div_q;

    clksw_seq #(.USE_SETTLE(USE_SETTLE)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .sel_xo_i     (sel_xo_i),
        .sleep_i      (sleep_i),
        .rc_stable_i  (rc_stable_i),
        .xo_stable_i  (xo_stable_i),
        .settle_done_i(settle_done),
        .settle_run_o (settle_run),
        .stat_o       (stat)
    );

    clksw_settle #(.LIM(SETTLE_LIM), .USE(USE_SETTLE)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .run_i (settle_run),
        .done_o(settle_done)
    );

    clksw_osc_ctl u_osc (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat),
        .pd_i   (osc_pd_i),
        .rc_en_o(rc_en_o),
        .xo_en_o(xo_en_o)
    );

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= clk_div_i;
    end

    assign src_xo_o  = (stat.act == SRC_XO);
    assign busy_o    = stat.busy;
    assign deep_ok_o = (stat.act == SRC_RC) && !stat.busy && !stat.asleep;
    assign clk_div_o = div_q;

    // R10
    deep_ok_chk: assert property (@(posedge clk) disable iff (rst)
        deep_ok_o |-> (!src_xo_o && !busy_o));
    // R11
    div_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (clk_div_o == $past(clk_div_i)));

endmodule

// File: tb/tb_clk_src_switch.sv
module tb_clk_src_switch;
    localparam int unsigned LIM = 50 * 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, pd = 1'b1, rcs = 1'b1, xos = 1'b0, slp = 1'b0;
    logic [2:0] div_i = '0;
    logic       rc_en, xo_en, src, busy, deep;
    logic [2:0] div_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clk_src_switch dut (
        .clk(clk), .rst(rst), .sel_xo_i(sel), .osc_pd_i(pd),
        .rc_stable_i(rcs), .xo_stable_i(xos), .sleep_i(slp),
        .clk_div_i(div_i), .rc_en_o(rc_en), .xo_en_o(xo_en),
        .src_xo_o(src), .busy_o(busy), .deep_ok_o(deep), .clk_div_o(div_o)
    );

    // {sel,pd,rc_stb,xo_stb, wait[15:0], exp_src,exp_rc_en,exp_xo_en,exp_busy}
    localparam logic [23:0] VEC [0:5] = '{
        {1'b0,1'b0,1'b1,1'b0, 16'd4,    1'b0,1'b1,1'b1,1'b0},
        {1'b1,1'b1,1'b1,1'b0, 16'd4,    1'b0,1'b1,1'b1,1'b1},
        {1'b1,1'b1,1'b1,1'b1, 16'd3300, 1'b1,1'b0,1'b1,1'b0},
        {1'b0,1'b1,1'b0,1'b1, 16'd4,    1'b1,1'b1,1'b1,1'b1},
        {1'b0,1'b1,1'b1,1'b1, 16'd4,    1'b0,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,1'b1, 16'd4,    1'b0,1'b1,1'b1,1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 src", src, 0); chk("R1 rc_en", rc_en, 1); chk("R1 xo_en", xo_en, 0);
        chk("R1 busy", busy, 0); chk("R1 div", div_o, 0); chk("R10 deep", deep, 1);

        // R2 R3 R4 R6 vector walk
        for (int i = 0; i < 6; i++) begin
            {sel, pd, rcs, xos} = VEC[i][23:20];
            tick(int'(VEC[i][19:4]));
            chk("R2 src", src, VEC[i][3]);
            chk("R3/R4 rc_en", rc_en, VEC[i][2]);
            chk("R3/R4 xo_en", xo_en, VEC[i][1]);
            chk("R2 busy", busy, VEC[i][0]);
        end

        // R5 settle length
        pd = 1; sel = 1;
        tick(LIM - 10);
        chk("R5 early src", src, 0); chk("R10 deep busy", deep, 0);
        tick(15);
        chk("R5 late src", src, 1); chk("R3 rc off", rc_en, 0); chk("R10 deep xo", deep, 0);

        // R6 back to RC fast, then R5 restart
        sel = 0; tick(3);
        chk("R6 src", src, 0);
        sel = 1; tick(1000); xos = 0; tick(2); xos = 1;
        tick(LIM - 10);
        chk("R5 restart src", src, 0);
        tick(20);
        chk("R5 restart done", src, 1);

        // R7 request withdrawn while pending
        sel = 0; tick(3);
        chk("R2 rc back", src, 0);
        xos = 0; sel = 1; tick(4);
        chk("R7 pend busy", busy, 1); chk("R4 xo pend", xo_en, 1);
        sel = 0; tick(4);
        chk("R7 held src", src, 0); chk("R7 held busy", busy, 1);
        rcs = 0; xos = 1; tick(LIM + 10);
        chk("R7 completed xo", src, 1); chk("R7 new pend", busy, 1);
        chk("R4 rc pend", rc_en, 1);
        rcs = 1; tick(3);
        chk("R7 served rc", src, 0); chk("R7 idle", busy, 0);

        // R8 R9 sleep with crystal active
        sel = 1; tick(LIM + 10);
        chk("R9 pre src", src, 1);
        slp = 1; tick(2);
        chk("R8 rc_en", rc_en, 0); chk("R8 xo_en", xo_en, 0);
        xos = 0; slp = 0; tick(1);
        chk("R9 wake src", src, 0); chk("R9 wake xo_en", xo_en, 1);
        chk("R9 wake busy", busy, 1);
        xos = 1; tick(LIM + 10);
        chk("R9 restore", src, 1); chk("R9 idle", busy, 0);

        // R9 sleep with RC only
        sel = 0; tick(3);
        slp = 1; tick(2); slp = 0; tick(1);
        chk("R9 rc src", src, 0); chk("R9 rc xo_en", xo_en, 0);
        chk("R9 rc busy", busy, 0); chk("R10 deep rc", deep, 1);

        // R11 divider field
        div_i = 3'd5;
        chk("R11 before", div_o, 0);
        tick(1);
        chk("R11 after", div_o, 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule